// File: doc/BRIEF.md
# TDM-Shared Memory Host Access Port

This block gives a host processor read and write access to a set of switch memories (transmit and receive data memories, receive and transmit connection memories) whose TDM side is served elsewhere on the chip. The host uses a multiplexed address/data bus. It first latches an address. The top bit of that address chooses between the memories and a small internal register file. A control register holds the memory select and page. Any number of accesses can follow inside one page without writing the control register again.

Memory transfers cannot happen on just any system clock cycle. They wait for a TDM clock edge that no TDM port is using. Each TDM clock arrives as a single-cycle tick. A fixed schedule hands alternate edges to the TDM ports, and the host gets the edges in between. The transmit connection memory follows the transmit port clock. All the other memories follow the frame-rate bit clock. A frame pulse on the frame-rate clock re-aligns that schedule. If the pulse is missing, the schedule simply runs on.

When a transfer is done, the port pulls the active-low acknowledge low. It holds it low for as long as the host keeps chip select asserted. This is the host's only means of back-pressure. The acknowledge is then driven high for one cycle and released. Register accesses need no TDM clock. An alarm register collects event bits behind a mask and drives an interrupt line. Any host write to the alarm register clears the event bits and reloads the mask.

Top module: `tdm_host_port`

## Requirements
- R1: Control register bits [1:0] select the memory: 0 transmit data, 1 receive data, 2 receive connection, 3 transmit connection. Bit [2] selects the page. Data written at one word under one select/page is read back only under that same select/page. Several accesses may follow one control write.
- R2: A latched address with bit 7 set is a memory access to word address[6:0]. With bit 7 clear it is a register access to index address[6:0].
- R3: Both TDM edge phases start even after reset. Even edges belong to the TDM ports and odd edges are free. A memory transfer takes place on the first free edge of its clock, and the acknowledge goes low in the cycle after that edge.
- R4: The acknowledge stays low, with valid read data on dout, while cs_n is low. After cs_n rises it is driven high with dta_oe set for one cycle, and then dta_oe drops. No new request is taken before the release.
- R5: With no transmit port ticks, transmit connection memory accesses get no acknowledge. With no frame-rate ticks, the other memories get none. Once the missing clock returns, the access completes with the correct data.
- R6: A frame-rate edge that coincides with frame_pulse is owned by the TDM ports, and the next edge is free. When frame_pulse never comes, accesses proceed normally.
- R7: Register 1 holds the mask in bits [7:4] (read/write) and the event bits in [3:0]. A pulse on alarm_evt[i] sets event bit i. irq is high when any set event bit is unmasked. Any write to register 1 clears the event bits and loads the mask from data bits [7:4].
- R8: Register 0 is the read/write control register and resets to 0. Register 2 reads stat_in. Register 3 counts frame pulses seen on frame-rate edges. Writes to registers 2 and 3 are ignored. Indices 4 to 127 read 0.
- R9: A register access is acknowledged in the cycle after the request is accepted, with no TDM tick needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Latches ad_in as the address while high |
| ad_in | input | 8 | Multiplexed address / write data |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dout | output | 8 | Read data, valid while dta_n is low |
| dta_n | output | 1 | Transfer acknowledge, active low |
| dta_oe | output | 1 | Acknowledge drive enable (low = released) |
| tx_tick | input | 1 | One-cycle pulse per transmit port clock edge |
| fr_tick | input | 1 | One-cycle pulse per frame-rate bit clock edge |
| frame_pulse | input | 1 | Frame alignment, sampled on fr_tick |
| alarm_evt | input | 4 | Alarm event pulses |
| stat_in | input | 8 | Status word from the datapath |
| irq | output | 1 | Interrupt, active high |

## Verification
The edge schedule is driven one tick at a time from reset. This shows that the owned edge gives no acknowledge and the free edge that follows does. A frame pulse placed on an edge that would otherwise be free shows that re-alignment pushes the transfer back one edge. With both clocks free-running at co-prime periods, distinct values written to every select/page pair expose any aliasing between memories or pages. One clock is then stopped at a time while the other keeps running. A wrong clock-domain choice would then either hang the access or complete it too early.

// File: rtl/tdm_host_port_pkg.sv
package tdm_host_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_REL  = 2'd3
  } port_state_e;

  localparam int REG_CTRL  = 0;
  localparam int REG_ALARM = 1;
  localparam int REG_STAT  = 2;
  localparam int REG_FCNT  = 3;
endpackage

// File: rtl/tdm_slot_phase.sv
module tdm_slot_phase #(
  parameter bit USE_FRAME = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic frame_pulse,
  output logic free_edge
);
  logic phase;
  logic fp_eff;

  assign fp_eff    = USE_FRAME & frame_pulse;
  assign free_edge = tick & phase & ~fp_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase <= 1'b0;
    else if (tick) phase <= fp_eff ? 1'b1 : ~phase;
  end

  // two consecutive free edges never occur: after a free edge the phase is even
  p_no_double_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    free_edge |=> !phase);
endmodule

// File: rtl/host_reg_file.sv
module host_reg_file
  import tdm_host_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 7,
  parameter int ALM_W  = 4,
  parameter int SEL_W  = 2,
  parameter int PAGE_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [SEL_W-1:0]  ctrl_sel,
  output logic [PAGE_W-1:0] ctrl_page,
  input  logic [ALM_W-1:0]  alarm_evt,
  input  logic [DATA_W-1:0] stat_in,
  input  logic              frame_evt,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] fcnt_q;
  logic [ALM_W-1:0]  mask_q;
  logic [ALM_W-1:0]  ind_q;
  logic [DATA_W-1:0] alarm_rd;
  logic              wr_ctrl, wr_alarm;

  assign wr_ctrl  = wr_en && (idx == IDX_W'(REG_CTRL));
  assign wr_alarm = wr_en && (idx == IDX_W'(REG_ALARM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fcnt_q <= '0;
      mask_q <= '0;
      ind_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_alarm) begin
        mask_q <= wdata[2*ALM_W-1:ALM_W];
        ind_q  <= alarm_evt;          // a new event in the same cycle survives
      end else begin
        ind_q  <= ind_q | alarm_evt;
      end
      if (frame_evt) fcnt_q <= fcnt_q + 1'b1;
    end
  end

  always_comb begin
    alarm_rd = '0;
    alarm_rd[2*ALM_W-1:0] = {mask_q, ind_q};
  end

  always_comb begin
    unique case (idx)
      IDX_W'(REG_CTRL):  rdata = ctrl_q;
      IDX_W'(REG_ALARM): rdata = alarm_rd;
      IDX_W'(REG_STAT):  rdata = stat_in;
      IDX_W'(REG_FCNT):  rdata = fcnt_q;
      default:           rdata = '0;
    endcase
  end

  assign ctrl_sel  = ctrl_q[SEL_W-1:0];
  assign ctrl_page = ctrl_q[SEL_W+PAGE_W-1:SEL_W];
  assign irq       = |(ind_q & mask_q);

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_alarm && alarm_evt == '0) |=> !irq);

  p_fcnt_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(REG_FCNT) && !frame_evt) |=> $stable(fcnt_q));
endmodule

// File: rtl/shared_mem_bank.sv
module shared_mem_bank #(
  parameter int DATA_W  = 8,
  parameter int NUM_MEM = 4,
  parameter int PAGE_W  = 1,
  parameter int WORD_W  = 7,
  parameter int SEL_W   = $clog2(NUM_MEM)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [PAGE_W-1:0] page,
  input  logic [WORD_W-1:0] word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int BANK_D = 2 ** (PAGE_W + WORD_W);

  logic [DATA_W-1:0] bank_rd [NUM_MEM];

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_bank
    logic [DATA_W-1:0] arr [BANK_D];
    always_ff @(posedge clk) begin
      if (we && sel == SEL_W'(g)) arr[{page, word}] <= wdata;
    end
    assign bank_rd[g] = arr[{page, word}];
  end

  assign rdata = bank_rd[sel];
endmodule

// File: rtl/tdm_host_port.sv
module tdm_host_port
  import tdm_host_port_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_MEM = 4,
  parameter int PAGE_W  = 1,
  parameter int ALM_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [DATA_W-1:0] ad_in,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [DATA_W-1:0] dout,
  output logic              dta_n,
  output logic              dta_oe,
  input  logic              tx_tick,
  input  logic              fr_tick,
  input  logic              frame_pulse,
  input  logic [ALM_W-1:0]  alarm_evt,
  input  logic [DATA_W-1:0] stat_in,
  output logic              irq
);
  localparam int WORD_W  = DATA_W - 1;
  localparam int SEL_W   = $clog2(NUM_MEM);
  localparam int TXC_SEL = NUM_MEM - 1;

  port_state_e       state;
  logic [DATA_W-1:0] addr_q;
  logic              pend_wr, pend_mem;
  logic [DATA_W-1:0] pend_data;
  logic [SEL_W-1:0]  pend_sel;
  logic [PAGE_W-1:0] pend_page;
  logic [WORD_W-1:0] pend_word;

  logic              accept, is_mem, reg_we;
  logic [DATA_W-1:0] reg_rdata, mem_rdata;
  logic [SEL_W-1:0]  ctrl_sel;
  logic [PAGE_W-1:0] ctrl_page;
  logic              tx_free, fr_free, slot_free_sel, mem_we;

  assign is_mem = addr_q[DATA_W-1];
  assign accept = (state == ST_IDLE) && !cs_n && (!rd_n || !wr_n);
  assign reg_we = accept && !is_mem && !wr_n;

  tdm_slot_phase #(.USE_FRAME(1'b0)) u_tx_phase (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .frame_pulse(1'b0), .free_edge(tx_free));

  tdm_slot_phase #(.USE_FRAME(1'b1)) u_fr_phase (
    .clk(clk), .rst_n(rst_n), .tick(fr_tick), .frame_pulse(frame_pulse), .free_edge(fr_free));

  assign slot_free_sel = (pend_sel == SEL_W'(TXC_SEL)) ? tx_free : fr_free;
  assign mem_we        = (state == ST_WAIT) && slot_free_sel && pend_wr;

  host_reg_file #(
    .DATA_W(DATA_W), .IDX_W(WORD_W), .ALM_W(ALM_W), .SEL_W(SEL_W), .PAGE_W(PAGE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .idx(addr_q[WORD_W-1:0]),
    .wdata(ad_in), .rdata(reg_rdata), .ctrl_sel(ctrl_sel), .ctrl_page(ctrl_page),
    .alarm_evt(alarm_evt), .stat_in(stat_in), .frame_evt(fr_tick & frame_pulse),
    .irq(irq));

  shared_mem_bank #(
    .DATA_W(DATA_W), .NUM_MEM(NUM_MEM), .PAGE_W(PAGE_W), .WORD_W(WORD_W), .SEL_W(SEL_W)
  ) u_mem (
    .clk(clk), .we(mem_we), .sel(pend_sel), .page(pend_page), .word(pend_word),
    .wdata(pend_data), .rdata(mem_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      dout      <= '0;
      pend_wr   <= 1'b0;
      pend_mem  <= 1'b0;
      pend_data <= '0;
      pend_sel  <= '0;
      pend_page <= '0;
      pend_word <= '0;
    end else begin
      if (ale) addr_q <= ad_in;
      unique case (state)
        ST_IDLE: if (accept) begin
          pend_wr   <= !wr_n;
          pend_mem  <= is_mem;
          pend_data <= ad_in;
          pend_sel  <= ctrl_sel;
          pend_page <= ctrl_page;
          pend_word <= addr_q[WORD_W-1:0];
          if (is_mem) begin
            state <= ST_WAIT;
          end else begin
            dout  <= reg_rdata;
            state <= ST_ACK;
          end
        end
        ST_WAIT: if (slot_free_sel) begin
          dout  <= pend_wr ? pend_data : mem_rdata;
          state <= ST_ACK;
        end
        ST_ACK:  if (cs_n) state <= ST_REL;
        ST_REL:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dta_n  = (state != ST_ACK);
  assign dta_oe = (state == ST_ACK) || (state == ST_REL);

  p_mem_free_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dta_n) && pend_mem) |-> $past(slot_free_sel));

  p_ack_withheld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !slot_free_sel) |=> dta_n);

  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dta_n && !cs_n) |=> !dta_n);

  p_release_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dta_n) |-> dta_oe);

  p_reg_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_mem) |=> !dta_n);
endmodule

// File: tb/tdm_host_port_tb.sv
module tdm_host_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic [7:0] ad_in = 8'h00;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] dout;
  logic       dta_n, dta_oe, irq;
  logic       tx_tick, fr_tick;
  logic       frame_pulse = 1'b0;
  logic [3:0] alarm_evt = 4'h0;
  logic [7:0] stat_in = 8'h3C;

  logic gen_tx = 1'b0, gen_fr = 1'b0, man_tx = 1'b0, man_fr = 1'b0;
  logic tx_run = 1'b0, fr_run = 1'b0;
  int   tx_cnt = 0, fr_cnt = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;

  assign tx_tick = gen_tx | man_tx;
  assign fr_tick = gen_fr | man_fr;

  always #5 clk = ~clk;

  tdm_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .dout(dout), .dta_n(dta_n), .dta_oe(dta_oe), .tx_tick(tx_tick),
    .fr_tick(fr_tick), .frame_pulse(frame_pulse), .alarm_evt(alarm_evt),
    .stat_in(stat_in), .irq(irq));

  // free-running TDM clock ticks: transmit every 5 cycles, frame-rate every 3
  always @(negedge clk) begin
    gen_tx <= 1'b0;
    gen_fr <= 1'b0;
    if (tx_run) begin
      tx_cnt <= (tx_cnt == 4) ? 0 : tx_cnt + 1;
      if (tx_cnt == 4) gen_tx <= 1'b1;
    end
    if (fr_run) begin
      fr_cnt <= (fr_cnt == 2) ? 0 : fr_cnt + 1;
      if (fr_cnt == 2) gen_fr <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start(input bit wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ale = 1'b1; ad_in = a;
    @(negedge clk);
    ale = 1'b0; ad_in = d; cs_n = 1'b0;
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
  endtask

  task automatic wait_ack(input int lim, output bit got);
    got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (!dta_n) begin got = 1'b1; break; end
    end
  endtask

  task automatic bus_end();
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk(dta_n && dta_oe, "R4 driven high", {dta_n, dta_oe}, 2'b11);
    @(negedge clk);
    chk(!dta_oe, "R4 released", dta_oe, 0);
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d,
                        input string req, output logic [7:0] rd);
    bit got;
    bus_start(wr, a, d);
    wait_ack(400, got);
    chk(got, req, got, 1);
    rd = dout;
    bus_end();
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] v;
    access(1'b0, a, 8'h00, req, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic wr_acc(input logic [7:0] a, input logic [7:0] d, input string req);
    logic [7:0] v;
    access(1'b1, a, d, req, v);
  endtask

  task automatic t_reset();
    chk(dta_n && !dta_oe && !irq, "R8 reset outputs", {dta_n, dta_oe, irq}, 3'b100);
    rd_check(8'h00, 8'h00, "R8 control reset");
    rd_check(8'h01, 8'h00, "R7 alarm reset");
  endtask

  task automatic t_reg_map();
    bit got;
    // R9: acknowledge in the first cycle after acceptance
    bus_start(1'b1, 8'h00, 8'h5A);
    wait_ack(1, got);
    chk(got, "R9 register ack latency", got, 1);
    bus_end();
    rd_check(8'h00, 8'h5A, "R8 control readback");
    wr_acc(8'h02, 8'hFF, "R8 write stat");
    rd_check(8'h02, 8'h3C, "R8 stat reads input");
    wr_acc(8'h03, 8'h77, "R8 write fcnt");
    rd_check(8'h03, 8'h00, "R8 fcnt write ignored");
    rd_check(8'h05, 8'h00, "R8 reserved index");
    rd_check(8'h40, 8'h00, "R2 reserved high index");
    wr_acc(8'h00, 8'h00, "R1 control set");
  endtask

  task automatic pulse_fr(input bit fp);
    @(negedge clk);
    man_fr = 1'b1; frame_pulse = fp;
    @(negedge clk);
    man_fr = 1'b0; frame_pulse = 1'b0;
  endtask

  task automatic t_mem_phase();
    // first TDM edges since reset: edge 1 owned, edge 2 free (R3)
    bus_start(1'b1, 8'h85, 8'hA1);
    @(negedge clk);
    chk(dta_n, "R3 waiting for edge", dta_n, 1);
    man_fr = 1'b1;
    @(negedge clk);
    man_fr = 1'b0;
    chk(dta_n, "R3 even edge owned", dta_n, 1);
    man_fr = 1'b1;
    @(negedge clk);
    man_fr = 1'b0;
    chk(!dta_n, "R3 odd edge free", dta_n, 0);
    bus_end();
  endtask

  task automatic t_frame();
    pulse_fr(1'b0);                     // phase now odd
    bus_start(1'b0, 8'h85, 8'h00);
    @(negedge clk);
    man_fr = 1'b1; frame_pulse = 1'b1;
    @(negedge clk);
    man_fr = 1'b0; frame_pulse = 1'b0;
    chk(dta_n, "R6 frame edge owned", dta_n, 1);
    man_fr = 1'b1;
    @(negedge clk);
    man_fr = 1'b0;
    chk(!dta_n, "R6 edge after frame free", dta_n, 0);
    chk(dout == 8'hA1, "R2 memory word readback", dout, 8'hA1);
    bus_end();
    rd_check(8'h03, 8'h01, "R8 frame count");
  endtask

  task automatic t_select();
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 2; p++) begin
        wr_acc(8'h00, 8'((p << 2) | s), "R1 select");
        wr_acc(8'h90, 8'(8'h30 + s * 2 + p), "R1 fill");
      end
    for (int s = 0; s < 4; s++)
      for (int p = 0; p < 2; p++) begin
        wr_acc(8'h00, 8'((p << 2) | s), "R1 select");
        rd_check(8'h90, 8'(8'h30 + s * 2 + p), "R1 isolation");
      end
    wr_acc(8'h00, 8'h05, "R1 select");
    wr_acc(8'h81, 8'hC1, "R1 same page");
    wr_acc(8'h82, 8'hC2, "R1 same page");
    rd_check(8'h81, 8'hC1, "R1 no control rewrite");
    rd_check(8'h82, 8'hC2, "R1 no control rewrite");
  endtask

  task automatic t_absent();
    bit got;
    wr_acc(8'h00, 8'h03, "R5 select tx conn");
    tx_run = 1'b0;
    bus_start(1'b0, 8'h90, 8'h00);
    wait_ack(30, got);
    chk(!got, "R5 no tx clock no ack", got, 0);
    tx_run = 1'b1;
    wait_ack(400, got);
    chk(got && dout == 8'h36, "R5 tx clock restored", dout, 8'h36);
    bus_end();
    wr_acc(8'h00, 8'h01, "R5 select rx data");
    fr_run = 1'b0;
    bus_start(1'b0, 8'h90, 8'h00);
    wait_ack(30, got);
    chk(!got, "R5 no frame clock no ack", got, 0);
    fr_run = 1'b1;
    wait_ack(400, got);
    chk(got && dout == 8'h32, "R5 frame clock restored", dout, 8'h32);
    bus_end();
  endtask

  task automatic evt(input logic [3:0] e);
    @(negedge clk);
    alarm_evt = e;
    @(negedge clk);
    alarm_evt = 4'h0;
  endtask

  task automatic t_alarm();
    wr_acc(8'h01, 8'hF0, "R7 mask all");
    evt(4'h4);
    chk(irq, "R7 event raises irq", irq, 1);
    rd_check(8'h01, 8'hF4, "R7 indication bit");
    wr_acc(8'h01, 8'hF0, "R7 clear write");
    chk(!irq, "R7 write clears irq", irq, 0);
    rd_check(8'h01, 8'hF0, "R7 indication cleared");
    wr_acc(8'h01, 8'h10, "R7 mask bit0");
    evt(4'h8);
    chk(!irq, "R7 masked event", irq, 0);
    rd_check(8'h01, 8'h18, "R7 masked indication");
    evt(4'h1);
    chk(irq, "R7 unmasked event", irq, 1);
  endtask

  task automatic t_hold();
    bit got;
    bit held = 1'b1;
    bus_start(1'b0, 8'h02, 8'h00);
    wait_ack(4, got);
    chk(got, "R4 ack", got, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (dta_n || dout != 8'h3C) held = 1'b0;
    end
    chk(held, "R4 ack held with cs low", held, 1);
    bus_end();
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_map();
    t_mem_phase();
    t_frame();
    tx_run = 1'b1;
    fr_run = 1'b1;
    t_select();
    t_absent();
    t_alarm();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule